// File: doc/BRIEF.md
# Keyed Byte-Mixing h-Function with Selectable Bit-Balanced Operations

This block is the keyed byte-mixing function of a Twofish-style cipher core, with one change: the key-mixing step between permutation layers can be chosen. A 32-bit input word is split into four byte lanes. Each lane passes through a chain of stages, one stage for each list (key) word. A stage first sends the byte through a fixed 8-bit permutation, q0 or q1. It then applies one of four bit-balanced operations: XOR with a key byte, bitwise inversion, rotation right by a chosen amount, or pass-through. A last fixed permutation layer follows the stages. The four bytes are then multiplied by a 4x4 MDS matrix over GF(2^8) to give the 32-bit result.

The stage count is fixed at elaboration (2, 3 or 4 list words). An optional output register, on by default, eases timing closure. Key scheduling, round structure and whitening belong to the surrounding core.

Top module: `tfm_mh`

## Requirements
- R1: While `rst_n` is low, `z_out` is zero. With `OUT_REG=1`, `z_out` shows the function of the inputs present at the previous rising clock edge (one cycle of latency).
- R2: Operation code 2'b00 XORs each byte with its key byte after the stage permutation. The result then equals the standard Twofish h-function output under the lane convention of R7.
- R3: Operation code 2'b01 replaces each post-permutation byte with its bitwise complement. The list words have no effect on the output.
- R4: Operation code 2'b10 rotates each post-permutation byte right by the unsigned value of `rot_amt` (0 to 7). An amount of 0 leaves the byte unchanged, so the output matches operation code 2'b11.
- R5: Operation code 2'b11 passes each post-permutation byte unchanged. The list words have no effect on the output.
- R6: `rot_amt` has no effect on the output unless the operation code is 2'b10.
- R7: Byte lane j (j = 0..3) of `x_in`, of every list word and of `z_out` occupies bits [31-8j : 24-8j]. Lane 0 uses bits 31:24 of the list word and lane 3 uses bits 7:0. One operation code and one rotate amount apply to all lanes in all stages.
- R8: List word i occupies `l_in[32i+31:32i]`. Stages run from word K-1 down to word 0. The permutations for lanes 0..3 are, for word 3: q1,q0,q0,q1; word 2: q1,q1,q0,q0; word 1: q0,q1,q0,q1; word 0: q0,q0,q1,q1. The final layer uses q1,q0,q1,q0.
- R9: Output lane i is the GF(2^8) sum over j of M[i][j]·y[j]. Reduction is by x^8+x^6+x^5+x^3+1, and M has rows {01,EF,5B,5B}, {5B,EF,EF,01}, {EF,5B,01,EF}, {EF,01,EF,5B}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| x_in | input | 32 | Word to be mixed, four byte lanes |
| l_in | input | 32*K_WORDS | Concatenated list words, word i at bits 32i+31:32i |
| op_code | input | 2 | Operation select: 00 key XOR, 01 invert, 10 rotate right, 11 pass |
| rot_amt | input | 3 | Right-rotate amount used by operation 10 |
| z_out | output | 32 | Mixed result |

## Verification
The assertions check, on every cycle, the local law of each stage and lane, comparing the byte that leaves the operation unit with the byte that leaves its permutation. Under XOR the difference must equal the paired key byte. Under invert and pass the byte is complemented or copied. Under rotate the bit count is kept, and an amount of zero changes nothing. The assertions also check the output register's reset value and its one-cycle latency. What only the bench can show is that the permutations, the stage ordering, the lane pairing and the MDS product give the right word overall. The bench shows this by comparing against an independent model, checking equality with the plain h-function, and showing that the key and the rotate amount are ignored at the output for the operations that must not use them.

// File: rtl/tfm_pkg.sv
package tfm_pkg;

  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    OP_KEYX = 2'b00,
    OP_INV  = 2'b01,
    OP_ROR  = 2'b10,
    OP_PASS = 2'b11
  } op_e;

  // nibble substitution tables, entry 0 in the top nibble
  localparam logic [63:0] QA_T0 = 64'h817D6F320B59ECA4;
  localparam logic [63:0] QA_T1 = 64'hECB81235F4A6709D;
  localparam logic [63:0] QA_T2 = 64'hBA5E6D90C8F32471;
  localparam logic [63:0] QA_T3 = 64'hD7F4126E9B3085CA;
  localparam logic [63:0] QB_T0 = 64'h28BDF76E31940AC5;
  localparam logic [63:0] QB_T1 = 64'h1E2B4C376DA5F908;
  localparam logic [63:0] QB_T2 = 64'h4C7516A90ED82B3F;
  localparam logic [63:0] QB_T3 = 64'hB951C3DE647F208A;

  // diffusion matrix, row-major, element (0,0) in the top byte
  localparam logic [127:0] MIX_M = 128'h01EF5B5B_5BEFEF01_EF5B01EF_EF01EF5B;

  // low byte of the field polynomial x^8+x^6+x^5+x^3+1
  localparam byte_t FIELD_LO = 8'h69;

  // lane masks: bit j set selects q1 for lane j
  localparam logic [3:0] MASK_W0  = 4'b1100;
  localparam logic [3:0] MASK_W1  = 4'b1010;
  localparam logic [3:0] MASK_W2  = 4'b0011;
  localparam logic [3:0] MASK_W3  = 4'b1001;
  localparam logic [3:0] MASK_FIN = 4'b0101;

  function automatic logic [3:0] tbl_nib(input logic [63:0] tbl, input logic [3:0] idx);
    logic [3:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) begin
      if (idx == 4'(i)) r = tbl[63-4*i -: 4];
    end
    return r;
  endfunction

  function automatic logic [3:0] nib_ror1(input logic [3:0] n);
    return {n[0], n[3:1]};
  endfunction

  function automatic byte_t q_perm(input logic use_q1, input byte_t x);
    logic [3:0] a0, b0, a1, b1, a2, b2, a3, b3, a4, b4;
    a0 = x[7:4];
    b0 = x[3:0];
    a1 = a0 ^ b0;
    b1 = a0 ^ nib_ror1(b0) ^ {a0[0], 3'b000};
    a2 = tbl_nib(use_q1 ? QB_T0 : QA_T0, a1);
    b2 = tbl_nib(use_q1 ? QB_T1 : QA_T1, b1);
    a3 = a2 ^ b2;
    b3 = a2 ^ nib_ror1(b2) ^ {a2[0], 3'b000};
    a4 = tbl_nib(use_q1 ? QB_T2 : QA_T2, a3);
    b4 = tbl_nib(use_q1 ? QB_T3 : QA_T3, b3);
    return {b4, a4};
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ((sh << 1) ^ FIELD_LO) : (sh << 1);
    end
    return acc;
  endfunction

  function automatic byte_t mix_coef(input int r, input int c);
    return MIX_M[127-8*(4*r+c) -: 8];
  endfunction

  function automatic byte_t ror8(input byte_t b, input logic [2:0] amt);
    logic [15:0] dbl;
    dbl = {b, b} >> amt;
    return dbl[7:0];
  endfunction

  function automatic byte_t op_apply(input op_e op, input logic [2:0] amt,
                                     input byte_t b, input byte_t key);
    byte_t r;
    case (op)
      OP_KEYX: r = b ^ key;
      OP_INV:  r = ~b;
      OP_ROR:  r = ror8(b, amt);
      default: r = b;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] word_mask(input int w);
    logic [3:0] m;
    case (w)
      0:       m = MASK_W0;
      1:       m = MASK_W1;
      2:       m = MASK_W2;
      default: m = MASK_W3;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/tfm_qperm.sv
module tfm_qperm #(
  parameter bit USE_Q1 = 1'b0
) (
  input  logic [7:0] d_in,
  output logic [7:0] d_out
);
  import tfm_pkg::*;

  always_comb d_out = q_perm(USE_Q1, d_in);

endmodule

// File: rtl/tfm_oplane.sv
module tfm_oplane (
  input  logic [1:0] op_code,
  input  logic [2:0] rot_amt,
  input  logic [7:0] d_in,
  input  logic [7:0] key_b,
  output logic [7:0] d_out
);
  import tfm_pkg::*;

  op_e op_w;

  always_comb begin
    op_w  = op_e'(op_code);
    d_out = op_apply(op_w, rot_amt, d_in, key_b);
  end

endmodule

// File: rtl/tfm_mix.sv
module tfm_mix #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0][7:0] y_in,
  output logic [8*LANES-1:0]    z_word
);
  import tfm_pkg::*;

  for (genvar r = 0; r < LANES; r++) begin : g_row
    byte_t row_acc;
    always_comb begin
      row_acc = '0;
      for (int c = 0; c < LANES; c++) begin
        row_acc = row_acc ^ gf_mul(mix_coef(r, c), y_in[c]);
      end
    end
    assign z_word[8*LANES-1-8*r -: 8] = row_acc;
  end

endmodule

// File: rtl/tfm_mh.sv
module tfm_mh #(
  parameter int K_WORDS = 2,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           x_in,
  input  logic [32*K_WORDS-1:0] l_in,
  input  logic [1:0]            op_code,
  input  logic [2:0]            rot_amt,
  output logic [31:0]           z_out
);
  import tfm_pkg::*;

  localparam int LANES = 4;
  localparam int WBITS = 32;

  // chain_w[s] is the lane set entering stage s; chain_w[K_WORDS] leaves the last stage
  logic [K_WORDS:0][LANES-1:0][7:0]  chain_w;
  logic [K_WORDS-1:0][LANES-1:0][7:0] q_out_w;
  logic [K_WORDS-1:0][LANES-1:0][7:0] op_out_w;
  logic [LANES-1:0][7:0]              fin_w;
  logic [WBITS-1:0]                   mix_w;

  for (genvar j = 0; j < LANES; j++) begin : g_split
    assign chain_w[0][j] = x_in[WBITS-1-8*j -: 8];
  end

  for (genvar s = 0; s < K_WORDS; s++) begin : g_stage
    localparam int         WIDX = K_WORDS - 1 - s;
    localparam logic [3:0] QM   = word_mask(WIDX);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      tfm_qperm #(.USE_Q1(QM[j])) u_q (
        .d_in  (chain_w[s][j]),
        .d_out (q_out_w[s][j])
      );
      tfm_oplane u_op (
        .op_code (op_code),
        .rot_amt (rot_amt),
        .d_in    (q_out_w[s][j]),
        .key_b   (l_in[WBITS*WIDX + WBITS-1-8*j -: 8]),
        .d_out   (op_out_w[s][j])
      );
      assign chain_w[s+1][j] = op_out_w[s][j];
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_final
    tfm_qperm #(.USE_Q1(MASK_FIN[j])) u_qf (
      .d_in  (chain_w[K_WORDS][j]),
      .d_out (fin_w[j])
    );
  end

  tfm_mix #(.LANES(LANES)) u_mix (
    .y_in   (fin_w),
    .z_word (mix_w)
  );

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) z_out <= '0;
      else        z_out <= mix_w;
    end
  end else begin : g_comb
    assign z_out = mix_w;
  end

endmodule

// File: rtl/tfm_mh_chk.sv
module tfm_mh_chk #(
  parameter int K_WORDS = 2,
  parameter bit OUT_REG = 1'b1
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [1:0]                         op_code,
  input logic [2:0]                         rot_amt,
  input logic [32*K_WORDS-1:0]              l_in,
  input logic [K_WORDS-1:0][3:0][7:0]       q_out_w,
  input logic [K_WORDS-1:0][3:0][7:0]       op_out_w,
  input logic [31:0]                        mix_w,
  input logic [31:0]                        z_out
);

  if (OUT_REG) begin : g_reg_chk
    p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> z_out == 32'h0);
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> z_out == $past(mix_w));
  end

  for (genvar s = 0; s < K_WORDS; s++) begin : g_s
    for (genvar j = 0; j < 4; j++) begin : g_j
      logic [7:0] kb;
      assign kb = l_in[32*(K_WORDS-1-s) + 31 - 8*j -: 8];
      // R7: every lane and stage follows the shared select
      p_keyxor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 2'b00 |-> (op_out_w[s][j] ^ q_out_w[s][j]) == kb);
      p_invert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 2'b01 |-> (op_out_w[s][j] ^ q_out_w[s][j]) == 8'hFF);
      p_rot_balance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 2'b10 |-> $countones(op_out_w[s][j]) == $countones(q_out_w[s][j]));
      p_rot_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'b10 && rot_amt == 3'd0) |-> op_out_w[s][j] == q_out_w[s][j]);
      p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 2'b11 |-> op_out_w[s][j] == q_out_w[s][j]);
    end
  end

endmodule

bind tfm_mh tfm_mh_chk #(.K_WORDS(K_WORDS), .OUT_REG(OUT_REG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_code  (op_code),
  .rot_amt  (rot_amt),
  .l_in     (l_in),
  .q_out_w  (q_out_w),
  .op_out_w (op_out_w),
  .mix_w    (mix_w),
  .z_out    (z_out)
);

// File: tb/tfm_mh_bench.sv
module tfm_mh_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk;
  logic         rst_n;
  logic [31:0]  x_in;
  logic [127:0] l_all;
  logic [1:0]   op_code;
  logic [2:0]   rot_amt;
  logic [31:0]  z2, z4;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  tfm_mh #(.K_WORDS(2)) u_tfm_mh (
    .clk(clk), .rst_n(rst_n), .x_in(x_in), .l_in(l_all[63:0]),
    .op_code(op_code), .rot_amt(rot_amt), .z_out(z2)
  );

  tfm_mh #(.K_WORDS(4)) u_tfm_mh_w4 (
    .clk(clk), .rst_n(rst_n), .x_in(x_in), .l_in(l_all),
    .op_code(op_code), .rot_amt(rot_amt), .z_out(z4)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  function automatic logic [3:0] tnib(input int q, input int t, input logic [3:0] i);
    logic [63:0] row;
    case (q*4 + t)
      0: row = 64'h817D6F320B59ECA4;
      1: row = 64'hECB81235F4A6709D;
      2: row = 64'hBA5E6D90C8F32471;
      3: row = 64'hD7F4126E9B3085CA;
      4: row = 64'h28BDF76E31940AC5;
      5: row = 64'h1E2B4C376DA5F908;
      6: row = 64'h4C7516A90ED82B3F;
      default: row = 64'hB951C3DE647F208A;
    endcase
    return row[(15 - int'(i))*4 +: 4];
  endfunction

  function automatic logic [7:0] mq(input int q, input logic [7:0] x);
    logic [3:0] a, b, na, nb;
    a = x >> 4; b = x & 8'h0F;
    na = a ^ b; nb = (a ^ ((b >> 1) | (b << 3)) ^ (a << 3)) & 4'hF;
    a = tnib(q, 0, na); b = tnib(q, 1, nb);
    na = a ^ b; nb = (a ^ ((b >> 1) | (b << 3)) ^ (a << 3)) & 4'hF;
    a = tnib(q, 2, na); b = tnib(q, 3, nb);
    return {b, a};
  endfunction

  // carry-less product, then reduce from the top
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = 0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (p[i]) p ^= 16'h169 << (i - 8);
    return p[7:0];
  endfunction

  // q selection: stage word w (4 = final), lane j
  function automatic int qsel(input int w, input int j);
    case (w)
      3: return (j == 0 || j == 3) ? 1 : 0;
      2: return (j <= 1) ? 1 : 0;
      1: return (j % 2 == 1) ? 1 : 0;
      0: return (j >= 2) ? 1 : 0;
      default: return (j % 2 == 0) ? 1 : 0;
    endcase
  endfunction

  function automatic logic [7:0] mcoef(input int r, input int c);
    logic [7:0] rows [4][4] = '{'{8'h01, 8'hEF, 8'h5B, 8'h5B},
                                '{8'h5B, 8'hEF, 8'hEF, 8'h01},
                                '{8'hEF, 8'h5B, 8'h01, 8'hEF},
                                '{8'hEF, 8'h01, 8'hEF, 8'h5B}};
    return rows[r][c];
  endfunction

  function automatic logic [7:0] bop(input logic [1:0] op, input logic [2:0] m,
                                     input logic [7:0] b, input logic [7:0] k);
    logic [7:0] r;
    r = b;
    if (op == 2'b00) r = b ^ k;
    else if (op == 2'b01) r = 8'hFF ^ b;
    else if (op == 2'b10) for (int n = 0; n < int'(m); n++) r = {r[0], r[7:1]};
    return r;
  endfunction

  function automatic logic [31:0] model(input int k, input logic [31:0] x, input logic [127:0] l,
                                        input logic [1:0] op, input logic [2:0] m);
    logic [7:0] y [4];
    logic [31:0] z;
    for (int j = 0; j < 4; j++) y[j] = x[31-8*j -: 8];
    for (int w = k - 1; w >= 0; w--)
      for (int j = 0; j < 4; j++)
        y[j] = bop(op, m, mq(qsel(w, j), y[j]), l[32*w + 31 - 8*j -: 8]);
    for (int j = 0; j < 4; j++) y[j] = mq(qsel(4, j), y[j]);
    for (int r = 0; r < 4; r++) begin
      logic [7:0] acc;
      acc = 0;
      for (int c = 0; c < 4; c++) acc ^= gmul(mcoef(r, c), y[c]);
      z[31-8*r -: 8] = acc;
    end
    return z;
  endfunction

  // plain h: permutation then key XOR, written without the op selector
  function automatic logic [31:0] plain_h(input int k, input logic [31:0] x, input logic [127:0] l);
    logic [7:0] y [4];
    logic [31:0] z;
    for (int j = 0; j < 4; j++) y[j] = x[31-8*j -: 8];
    for (int w = k - 1; w >= 0; w--)
      for (int j = 0; j < 4; j++) y[j] = mq(qsel(w, j), y[j]) ^ l[32*w + 31 - 8*j -: 8];
    for (int j = 0; j < 4; j++) y[j] = mq(qsel(4, j), y[j]);
    for (int r = 0; r < 4; r++) begin
      logic [7:0] acc;
      acc = 0;
      for (int c = 0; c < 4; c++) acc ^= gmul(mcoef(r, c), y[c]);
      z[31-8*r -: 8] = acc;
    end
    return z;
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // drive at a falling edge, result is sampled at the next falling edge
  task automatic apply(input logic [31:0] x, input logic [127:0] l,
                       input logic [1:0] op, input logic [2:0] m);
    x_in = x; l_all = l; op_code = op; rot_amt = m;
    @(negedge clk);
  endtask

  task automatic run_both(input string req, input logic [31:0] x, input logic [127:0] l,
                          input logic [1:0] op, input logic [2:0] m);
    apply(x, l, op, m);
    chk(req, z2, model(2, x, l, op, m));
    chk(req, z4, model(4, x, l, op, m));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0]  ref_z2;
    logic [31:0]  xr;
    logic [127:0] lr;
    void'($urandom(32'd20240611));
    rst_n = 0;
    x_in = 32'hDEADBEEF; l_all = {4{32'h13579BDF}}; op_code = 2'b00; rot_amt = 3'd5;
    @(negedge clk); @(negedge clk);
    chk("R1 reset", z2, 32'h0);
    chk("R1 reset", z4, 32'h0);
    rst_n = 1;

    // R1 latency: one edge after a change, the output follows
    apply(32'h01234567, {4{32'h89ABCDEF}}, 2'b00, 3'd0);
    chk("R1 latency", z2, model(2, 32'h01234567, {4{32'h89ABCDEF}}, 2'b00, 3'd0));

    // R2: key XOR equals plain h
    run_both("R2 zero", 32'h0, 128'h0, 2'b00, 3'd0);
    apply(32'hFFFFFFFF, 128'hFFFFFFFF_00000000_A5A5A5A5_3C3C3C3C, 2'b00, 3'd6);
    chk("R2 plain", z2, plain_h(2, 32'hFFFFFFFF, 128'hFFFFFFFF_00000000_A5A5A5A5_3C3C3C3C));
    chk("R2 plain", z4, plain_h(4, 32'hFFFFFFFF, 128'hFFFFFFFF_00000000_A5A5A5A5_3C3C3C3C));

    // R3 and R5: list words have no effect
    for (int op = 1; op < 4; op += 2) begin
      logic [31:0] a2, a4;
      apply(32'h5A17C3E9, 128'h0, 2'(op), 3'd2);
      a2 = z2; a4 = z4;
      chk(op == 1 ? "R3 model" : "R5 model", a2, model(2, 32'h5A17C3E9, 128'h0, 2'(op), 3'd2));
      apply(32'h5A17C3E9, {4{32'hC0FFEE11}}, 2'(op), 3'd2);
      chk(op == 1 ? "R3 key ignored" : "R5 key ignored", z2, a2);
      chk(op == 1 ? "R3 key ignored" : "R5 key ignored", z4, a4);
    end

    // R4: every rotate amount; amount 0 matches pass-through
    for (int m = 0; m < 8; m++) run_both("R4 rotate", 32'h9E3779B9, {4{32'h7F4A7C15}}, 2'b10, 3'(m));
    apply(32'h9E3779B9, {4{32'h7F4A7C15}}, 2'b11, 3'd0);
    ref_z2 = z2;
    apply(32'h9E3779B9, {4{32'h7F4A7C15}}, 2'b10, 3'd0);
    chk("R4 zero rot", z2, ref_z2);

    // R6: rotate amount ignored outside rotate mode
    for (int op = 0; op < 4; op++) begin
      if (op == 2) continue;
      apply(32'h31415926, {4{32'h27182818}}, 2'(op), 3'd0);
      ref_z2 = z2;
      apply(32'h31415926, {4{32'h27182818}}, 2'(op), 3'd7);
      chk("R6 rot ignored", z2, ref_z2);
    end

    // R7: single key byte in each lane position
    for (int j = 0; j < 4; j++)
      run_both("R7 lane pairing", 32'h00000000, 128'(32'hA7) << (24 - 8*j), 2'b00, 3'd0);
    // R8: single nonzero word in each word slot
    for (int w = 0; w < 4; w++)
      run_both("R8 word order", 32'h11223344, 128'h6B2D19F0 << (32*w), 2'b00, 3'd0);
    // R9: single input byte reaches all four outputs through the matrix
    run_both("R9 matrix", 32'h80000000, 128'h0, 2'b11, 3'd0);
    run_both("R9 matrix", 32'h000000FF, 128'h0, 2'b01, 3'd0);

    // constrained random over all codes and amounts
    for (int i = 0; i < 400; i++) begin
      xr = $urandom;
      lr = {$urandom, $urandom, $urandom, $urandom};
      run_both("R2-mix random", xr, lr, 2'(i % 4), 3'((i / 4) % 8));
      if (i % 4 == 0) chk("R2 random plain", z2, plain_h(2, xr, lr));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule